// File: doc/BRIEF.md
# Dual-Mode FIFO Read Port

This block is the read half of a single-clock synchronous FIFO, with a small write stub in front of it so that it can be used and checked on its own. The write stub places words into a RAM of `DEPTH` entries. The read side moves words out of that RAM into an output register, which drives `rd_data_o`. Reads are requested with an active-low read enable.

One of two read behaviours is chosen by the level of `fwft_mode_i` while the synchronous reset is held. In standard mode every word, including the first one, must be asked for with a read. A flag that is low when no word is readable blocks reads when the FIFO is empty. In fall-through mode the oldest stored word moves into the output register without a request. A ready flag that is low while the output holds an unread word takes the place of the empty flag. A read in fall-through mode consumes the word being shown and shows the next one at once.

The write pointer reaches the read logic through a pipeline of `SYNC_STAGES` registers, which defaults to 2. This gives each mode a fixed latency from a write until that word can be seen on the read side.

Top module: `fifo_dual_read`

## Requirements
- R1: In standard mode, with `rd_en_n_i` low and `empty_n_o` high at a rising edge, the oldest unread word is loaded into `rd_data_o` at that edge.
- R2: A cycle with `rd_en_n_i` high leaves `rd_data_o` unchanged, in either mode, once a word has been shown.
- R3: A read request while nothing is readable (standard: `empty_n_o` low; fall-through: `ready_n_o` high) changes neither `rd_data_o` nor the read order.
- R4: In fall-through mode, a word written into an empty FIFO at rising edge W appears on `rd_data_o` after edge W+3, and `ready_n_o` goes low at that same edge, with `rd_en_n_i` held high.
- R5: In fall-through mode, `ready_n_o` goes high on the edge where a read consumes the shown word and no further word is readable.
- R6: In standard mode, `empty_n_o` goes low on the edge that reads the last stored word. After a write into an empty FIFO at edge W, it stays low after edges W and W+1 and goes high after edge W+2.
- R7: The mode is captured only while `rst_n` is low. Changing `fwft_mode_i` afterwards has no effect.
- R8: In fall-through mode, each later word is advanced only by a read. The word that follows appears in the same edge as the read, with first-in first-out order kept.
- R9: After reset, `rd_data_o` is zero, `empty_n_o` is low, `ready_n_o` is high and `full_o` is low.
- R10: `full_o` is high when `DEPTH` words are held in the RAM. A write while `full_o` is high is dropped and leaves the stored order unchanged.
- R11: The flag of the mode that is not selected is held at its idle level: `ready_n_o` stays high in standard mode, and `empty_n_o` stays low in fall-through mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by write and read sides |
| rst_n | input | 1 | Synchronous active-low master reset |
| fwft_mode_i | input | 1 | Mode level sampled during reset: 1 = fall-through, 0 = standard |
| wr_en_i | input | 1 | Write strobe, active high |
| wr_data_i | input | DATA_W | Word to write |
| full_o | output | 1 | High when the RAM holds DEPTH words |
| rd_en_n_i | input | 1 | Read request, active low |
| rd_data_o | output | DATA_W | Output register |
| empty_n_o | output | 1 | Standard mode: low when no word is readable |
| ready_n_o | output | 1 | Fall-through mode: low when the output holds an unread word |

## Verification
A corrupted read pointer shows on the next read. That read presents a word out of order, or a repeated word, on `rd_data_o` one edge after the request. A wrong readable-word count shows at the flags. `empty_n_o` or `ready_n_o` then changes one edge too early or too late against the two-cycle and three-cycle write latencies, and a stray fall-through load changes the data with no request made. A mode register that follows its input after reset shows within four edges of the next write, because the word falls through in standard mode. The bench runs each mode against a queue of written words.

// File: rtl/fifo_rd_pkg.sv
// Package: shared types for the dual-mode FIFO read port.
// Assumes: nothing; pure type definitions.
package fifo_rd_pkg;

    // Read behaviour chosen at master reset
    typedef enum logic {
        RD_STANDARD = 1'b0,
        RD_FALLTHRU = 1'b1
    } rd_mode_e;

endpackage

// File: rtl/fifo_wr_stub.sv
// Module: fifo_wr_stub
// Write side of the FIFO: holds the RAM, the write pointer and the full flag.
// The RAM read port is combinational on the read address from the read side.
// Assumes: DEPTH is a power of two; pointers carry one wrap bit above the address.
module fifo_wr_stub #(
    parameter int DATA_W = 18,
    parameter int DEPTH  = 16,
    localparam int AW    = $clog2(DEPTH),
    localparam int PW    = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [PW-1:0]     rptr_i,
    output logic [PW-1:0]     wptr_o,
    output logic [DATA_W-1:0] ram_word_o,
    output logic              full_o
);

    localparam logic [PW-1:0] FULL_CNT = PW'(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PW-1:0]     wptr_q;
    logic [PW-1:0]     used;
    logic              wr_fire;

    // Occupancy seen by the writer and the resulting full flag
    always_comb begin
        used    = wptr_q - rptr_i;
        full_o  = (used == FULL_CNT);
        wr_fire = wr_en_i && !full_o;
    end

    // Store accepted words into the RAM
    always_ff @(posedge clk) begin
        if (wr_fire) begin
            mem[wptr_q[AW-1:0]] <= wr_data_i;
        end
    end

    // Advance the write pointer on every accepted write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_q <= '0;
        end else if (wr_fire) begin
            wptr_q <= wptr_q + 1'b1;
        end
    end

    // Present the word at the read address
    always_comb begin
        ram_word_o = mem[rptr_i[AW-1:0]];
    end

    assign wptr_o = wptr_q;

    // R10: a write while full leaves the write pointer where it was
    a_r10_drop_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && wr_en_i) |=> $stable(wptr_q));

    // R10: occupancy never exceeds the RAM size
    a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (used <= FULL_CNT));

endmodule

// File: rtl/fifo_ptr_delay.sv
// Module: fifo_ptr_delay
// Carries the write pointer to the read side through STAGES registers, so that
// the read side sees writes with a fixed latency.
// Assumes: STAGES >= 1; reset clears every stage to zero.
module fifo_ptr_delay #(
    parameter int PW     = 5,
    parameter int STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] ptr_i,
    output logic [PW-1:0] ptr_o
);

    logic [PW-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            // One register stage of the pointer pipeline
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stage_q[g] <= '0;
                end else if (g == 0) begin
                    stage_q[g] <= ptr_i;
                end else begin
                    stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    assign ptr_o = stage_q[STAGES-1];

endmodule

// File: rtl/fifo_rd_ctrl.sv
// Module: fifo_rd_ctrl
// Read side: read pointer, output register and the two mode flags.
// Standard mode loads a word only on request. Fall-through mode keeps the
// output register filled whenever a word is readable.
// Assumes: wptr_vis_i is the delayed write pointer; the mode is captured only
// while rst_n is low.
module fifo_rd_ctrl
    import fifo_rd_pkg::*;
#(
    parameter int DATA_W = 18,
    parameter int PW     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fwft_sel_i,
    input  logic              rd_en_n_i,
    input  logic [PW-1:0]     wptr_vis_i,
    input  logic [DATA_W-1:0] ram_word_i,
    output logic [PW-1:0]     rptr_o,
    output logic [DATA_W-1:0] data_o,
    output logic              empty_n_o,
    output logic              ready_n_o
);

    rd_mode_e          mode_q;
    logic [PW-1:0]     rptr_q;
    logic [DATA_W-1:0] data_q;
    logic              valid_q;
    logic [PW-1:0]     avail;
    logic              have_word;
    logic              is_ft;
    logic              std_fire;
    logic              ft_load;
    logic              ft_drain;
    logic              pop;

    // Capture the mode while master reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= rd_mode_e'(fwft_sel_i);
        end
    end

    // Readable words and the decisions taken at the next edge
    always_comb begin
        is_ft     = (mode_q == RD_FALLTHRU);
        avail     = wptr_vis_i - rptr_q;
        have_word = (avail != '0);
        std_fire  = !is_ft && !rd_en_n_i && have_word;
        ft_load   = is_ft && have_word && (!valid_q || !rd_en_n_i);
        ft_drain  = is_ft && !have_word && valid_q && !rd_en_n_i;
        pop       = std_fire || ft_load;
    end

    // Read pointer moves once for each word taken from the RAM
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rptr_q <= '0;
        end else if (pop) begin
            rptr_q <= rptr_q + 1'b1;
        end
    end

    // Output register loads the RAM word on every pop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (pop) begin
            data_q <= ram_word_i;
        end
    end

    // Fall-through occupancy of the output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
        end else if (ft_load) begin
            valid_q <= 1'b1;
        end else if (ft_drain) begin
            valid_q <= 1'b0;
        end
    end

    // Flags: each mode drives its own, the other one rests idle
    always_comb begin
        empty_n_o = is_ft ? 1'b0 : have_word;
        ready_n_o = is_ft ? !valid_q : 1'b1;
    end

    assign rptr_o = rptr_q;
    assign data_o = data_q;

    // R1: a standard read of an available word advances the read pointer by one
    a_r1_std_read_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_ft && !rd_en_n_i && have_word) |=> (rptr_q == $past(rptr_q) + 1'b1));

    // R2: an idle standard cycle holds the output
    a_r2_std_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_ft && rd_en_n_i) |=> $stable(data_q));

    // R3: a request on an empty standard FIFO moves nothing
    a_r3_empty_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_ft && !have_word) |=> ($stable(rptr_q) && $stable(data_q)));

    // R4: a readable word with an empty output register is loaded without a request
    a_r4_auto_load: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ft && !valid_q && have_word) |=> valid_q);

    // R5: consuming the last word drops ready
    a_r5_ready_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ft && valid_q && !rd_en_n_i && !have_word) |=> !valid_q);

    // R7: the mode never changes outside reset
    a_r7_mode_locked: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(mode_q));

    // R8: a shown word stays until it is read
    a_r8_ft_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ft && valid_q && rd_en_n_i) |=> ($stable(data_q) && valid_q));

    // R11: the idle flag of the other mode stays at rest
    a_r11_idle_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ft ? !empty_n_o : ready_n_o));

endmodule

// File: rtl/fifo_dual_read.sv
// Module: fifo_dual_read (top)
// Single-clock FIFO whose read behaviour, standard or fall-through, is chosen
// at master reset. Wires the write stub, the pointer delay and the read side.
// Assumes: DEPTH is a power of two; rst_n is synchronous and active low.
module fifo_dual_read #(
    parameter int DATA_W      = 18,
    parameter int DEPTH       = 16,
    parameter int SYNC_STAGES = 2,
    localparam int AW         = $clog2(DEPTH),
    localparam int PW         = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fwft_mode_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic              full_o,
    input  logic              rd_en_n_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              empty_n_o,
    output logic              ready_n_o
);

    logic [PW-1:0]     wptr;
    logic [PW-1:0]     wptr_vis;
    logic [PW-1:0]     rptr;
    logic [DATA_W-1:0] ram_word;

    fifo_wr_stub #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) i_wr (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en_i),
        .wr_data_i  (wr_data_i),
        .rptr_i     (rptr),
        .wptr_o     (wptr),
        .ram_word_o (ram_word),
        .full_o     (full_o)
    );

    fifo_ptr_delay #(
        .PW     (PW),
        .STAGES (SYNC_STAGES)
    ) i_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .ptr_i (wptr),
        .ptr_o (wptr_vis)
    );

    fifo_rd_ctrl #(
        .DATA_W (DATA_W),
        .PW     (PW)
    ) i_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .fwft_sel_i (fwft_mode_i),
        .rd_en_n_i  (rd_en_n_i),
        .wptr_vis_i (wptr_vis),
        .ram_word_i (ram_word),
        .rptr_o     (rptr),
        .data_o     (rd_data_o),
        .empty_n_o  (empty_n_o),
        .ready_n_o  (ready_n_o)
    );

    // R9: the edge after a reset cycle leaves the outputs in their reset state
    a_r9_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (rd_data_o == '0 && !empty_n_o && ready_n_o && !full_o));

endmodule

// File: tb/test_fifo_dual_read.sv
// Directed bench for fifo_dual_read with a queue of written words as reference.
module test_fifo_dual_read;

    localparam int CLK_P  = 10;
    localparam int DW     = 18;
    localparam int DEPTH  = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fwft_mode = 1'b0;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          rd_en_n = 1'b1;
    logic          full;
    logic [DW-1:0] rd_data;
    logic          empty_n;
    logic          ready_n;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    logic [DW-1:0] model_q[$];

    always #(CLK_P/2) clk = ~clk;

    fifo_dual_read #(.DATA_W(DW), .DEPTH(DEPTH)) i_fifo_dual_read (
        .clk         (clk),
        .rst_n       (rst_n),
        .fwft_mode_i (fwft_mode),
        .wr_en_i     (wr_en),
        .wr_data_i   (wr_data),
        .full_o      (full),
        .rd_en_n_i   (rd_en_n),
        .rd_data_o   (rd_data),
        .empty_n_o   (empty_n),
        .ready_n_o   (ready_n)
    );

    task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_reset(input bit ft);
        rst_n = 1'b0; fwft_mode = ft; wr_en = 1'b0; rd_en_n = 1'b1;
        model_q.delete();
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        check(rd_data == '0, "R9 data", rd_data, '0);
        check(!empty_n && ready_n && !full, "R9 flags",
              {empty_n, ready_n, full}, 3'b010);
    endtask

    task automatic write_word(input logic [DW-1:0] d);
        wr_en = 1'b1; wr_data = d;
        if (!full) model_q.push_back(d);
        tick();
        wr_en = 1'b0;
    endtask

    task automatic read_cycle();
        rd_en_n = 1'b0;
        tick();
        rd_en_n = 1'b1;
    endtask

    // Standard mode: flag latency, one read, read when empty, idle holds
    task automatic t_standard();
        logic [DW-1:0] e;
        do_reset(1'b0);
        write_word(18'h1A5A5);
        check(!empty_n, "R6 low after W", empty_n, 0);
        tick();
        check(!empty_n, "R6 low after W+1", empty_n, 0);
        tick();
        check(empty_n, "R6 high after W+2", empty_n, 1);
        check(rd_data == '0, "R1 no data before request", rd_data, '0);
        e = model_q.pop_front();
        read_cycle();
        check(rd_data == e, "R1 first word read", rd_data, e);
        check(!empty_n, "R6 low after last read", empty_n, 0);
        check(ready_n, "R11 ready idle in standard", ready_n, 1);
        read_cycle();
        check(rd_data == e, "R3 read on empty ignored", rd_data, e);
        for (int i = 0; i < 5; i++) write_word(DW'(18'h100 + i * 7));
        repeat (3) tick();
        for (int i = 0; i < 5; i++) begin
            e = model_q.pop_front();
            read_cycle();
            check(rd_data == e, "R1 burst order", rd_data, e);
            tick();
            check(rd_data == e, "R2 idle hold", rd_data, e);
        end
        check(!empty_n, "R6 empty after burst", empty_n, 0);
    endtask

    // Fall-through mode: three-edge latency, hold, same-edge advance, drain
    task automatic t_fallthru();
        logic [DW-1:0] e;
        do_reset(1'b1);
        write_word(18'h2C3C3);
        check(ready_n, "R4 not ready after W", ready_n, 1);
        tick();
        check(ready_n, "R4 not ready after W+1", ready_n, 1);
        tick();
        check(ready_n, "R4 not ready after W+2", ready_n, 1);
        tick();
        e = model_q[0];
        check(!ready_n, "R4 ready after W+3", ready_n, 0);
        check(rd_data == e, "R4 first word fell through", rd_data, e);
        for (int i = 0; i < 4; i++) write_word(DW'(18'h3000 + i * 3));
        repeat (5) tick();
        check(rd_data == e, "R8 no advance without read", rd_data, e);
        check(!empty_n, "R11 empty idle in fall-through", empty_n, 0);
        void'(model_q.pop_front());
        for (int i = 0; i < 4; i++) begin
            e = model_q.pop_front();
            read_cycle();
            check(rd_data == e && !ready_n, "R8 next word same edge", rd_data, e);
        end
        read_cycle();
        check(ready_n, "R5 ready drops on last read", ready_n, 1);
        read_cycle();
        check(rd_data == e, "R3 read when not ready ignored", rd_data, e);
    endtask

    // Mode input changed after reset has no effect
    task automatic t_mode_lock();
        logic [DW-1:0] e;
        do_reset(1'b0);
        fwft_mode = 1'b1;
        write_word(18'h0BEEF);
        repeat (4) tick();
        check(rd_data == '0, "R7 no fall-through after reset", rd_data, '0);
        check(empty_n && ready_n, "R7 standard flags kept", {empty_n, ready_n}, 2'b11);
        e = model_q.pop_front();
        read_cycle();
        check(rd_data == e, "R7 standard read", rd_data, e);
        fwft_mode = 1'b0;
    endtask

    // Fill to full, drop one extra write, drain in order
    task automatic t_full();
        logic [DW-1:0] e;
        do_reset(1'b0);
        for (int i = 0; i < DEPTH; i++) write_word(DW'(18'h20000 + i));
        check(full, "R10 full at DEPTH", full, 1);
        write_word(18'h3FFFF);
        check(model_q.size() == DEPTH, "R10 model depth", DW'(model_q.size()), DW'(DEPTH));
        repeat (3) tick();
        for (int i = 0; i < DEPTH; i++) begin
            e = model_q.pop_front();
            read_cycle();
            check(rd_data == e, "R10 drain order", rd_data, e);
        end
        check(!empty_n && !full, "R10 empty after drain", {empty_n, full}, 2'b00);
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        tick();
        t_standard();
        t_fallthru();
        t_mode_lock();
        t_full();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule